// File: doc/BRIEF.md
# Multi-Mode Pixel Bus Unpacker

This block sits between a wide pixel port and the colour lookup stage of a display pipeline. A load strobe, one pixel-clock cycle wide and marking a rising edge of the shift clock, captures a whole 32-bit bus word in one go. The block then presents one pixel on every following pixel-clock edge. Which bits form each pixel depends on the active mode. The packed modes carry 1, 2, 4, 8 or 16 bits per pixel. In nibble-select mode, one 4-bit field is taken from each byte. In true-colour mode, the word is split into three colour components and an overlay index. In pass-through mode, a separate 8-bit port is forwarded on every cycle.

Software programs three small registers through an address/data/write-strobe port: the mode code, the pixels-per-load ratio and an 8-bit read mask. Written values wait in shadow storage and become active only at the next load strobe, so a bus load that is already being shifted out never changes its layout partway through. If the pixel clock runs past the programmed ratio before the next load, the block holds the last pixel and raises an underrun flag.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset the block is in pass-through mode, with the ratio at 1 and the mask at 0xFF; pix_idx, red, green, blue and underrun are all zero while vga_px is zero.
- R2: When pass-through (mode code 0) is active, each clock edge registers vga_px. The value vga_px & mask then appears on pix_idx[7:0], pix_idx[15:8] is zero, and no underrun is ever raised.
- R3: A clock edge with sclk_stb high captures pix_bus. Pixel group 0 is shown after that edge, and each later edge without a strobe advances by one group, starting from the lowest-numbered bits.
- R4: Mode codes 1, 2, 3, 4 and 5 select 1, 2, 4, 8 and 16 bits per pixel (b). Group k is pix_bus[k*b +: b], zero-extended to 16 bits.
- R5: Mode code 6 is nibble-select. nib_hi is sampled at the capture edge. With nib_hi at 0, group k is pix_bus[8k +: 4]; with nib_hi at 1, group k is pix_bus[8k+4 +: 4].
- R6: Mode code 7 is true-colour. blue takes pix_bus[31:24], green takes pix_bus[23:16] and red takes pix_bus[15:8], while pix_bus[7:0] is the overlay index on pix_idx. In every other mode, red, green and blue are zero.
- R7: pix_idx[7:0] is ANDed bitwise with the active mask, and pix_idx[15:8] is not masked. A mask of zero removes the true-colour overlay but leaves the colour outputs unchanged.
- R8: With ratio R (a value of 0 counts as 1, and a value above 32 counts as 32), the group counter stops at R-1. An edge without a strobe after that point holds the last pixel and sets underrun, which stays set until the next strobe edge clears it.
- R9: The register map is address 0 for mode (code in bits [2:0], bits [7:3] have no effect), address 1 for ratio (bits [5:0]) and address 2 for mask. A write to address 3 changes nothing.
- R10: Register writes take effect only at the next strobe edge. Groups still being shifted from the current load keep the old settings.
- R11: Writing mode code 0 also resets the stored ratio to 1 and the stored mask to 0xFF.
- R12: Writing a nonzero mode code leaves the stored ratio and mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| sclk_stb | input | 1 | Shift-clock rising-edge strobe; captures pix_bus |
| pix_bus | input | 32 | Packed pixel bus word |
| nib_hi | input | 1 | Nibble select for mode 6 (1 = upper nibble of each byte) |
| vga_px | input | 8 | Pass-through pixel input |
| pix_idx | output | 16 | Palette index or overlay index |
| red | output | 8 | True-colour red component |
| green | output | 8 | True-colour green component |
| blue | output | 8 | True-colour blue component |
| underrun | output | 1 | Pixel clock ran past the ratio since the last load |

## Verification
Every packed width is driven with a walking-nibble word, a word with halves of all ones and all zeros, and several multiplicative-hash words. Together these show whether group order, field width and zero extension are right, and they expose shifts off by one group or one bit. Nibble-select mode is run with both flag values on the same words, so picking the wrong half of a byte cannot go unnoticed. In pass-through mode, all 256 input codes are swept. Further directed sequences check the following: a mask change made partway through a load, ratios of 0 and 2 and the resulting underrun, the effect of a mode-0 write on the other registers, the ignored address and the ignored upper mode bits.

// File: rtl/pixel_unpacker_pkg.sv
package pixel_unpacker_pkg;
    localparam int BUS_W    = 32;
    localparam int IDX_W    = 16;
    localparam int MASK_W   = 8;
    localparam int RATIO_W  = 6;
    localparam int CNT_W    = $clog2(BUS_W);
    localparam int SHIFT_W  = CNT_W + $clog2(IDX_W) + 1;
    localparam logic [RATIO_W-1:0] RATIO_DEF = RATIO_W'(1);
    localparam logic [MASK_W-1:0]  MASK_DEF  = '1;

    typedef enum logic [2:0] {
        MD_PASS   = 3'd0,
        MD_BPP1   = 3'd1,
        MD_BPP2   = 3'd2,
        MD_BPP4   = 3'd3,
        MD_BPP8   = 3'd4,
        MD_BPP16  = 3'd5,
        MD_NIBBLE = 3'd6,
        MD_TRUE   = 3'd7
    } px_mode_e;

    typedef struct packed {
        px_mode_e              mode;
        logic [RATIO_W-1:0]    ratio;
        logic [MASK_W-1:0]     mask;
    } px_cfg_t;

    typedef struct packed {
        logic [BUS_W-1:0]      word;
        logic [CNT_W-1:0]      cnt;
        logic                  under;
        logic                  nib;
    } px_state_t;
endpackage

// File: rtl/pixel_cfg_regs.sv
module pixel_cfg_regs
    import pixel_unpacker_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output px_cfg_t     shadow
);
    px_cfg_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (we) begin
            case (addr)
                2'd0: begin
                    sh_d.mode = px_mode_e'(wdata[2:0]);
                    if (wdata[2:0] == 3'd0) begin
                        sh_d.ratio = RATIO_DEF;
                        sh_d.mask  = MASK_DEF;
                    end
                end
                2'd1: sh_d.ratio = wdata[RATIO_W-1:0];
                2'd2: sh_d.mask  = wdata[MASK_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{mode: MD_PASS, ratio: RATIO_DEF, mask: MASK_DEF};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign shadow = sh_q;

    AST_PASS_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd0 && wdata[2:0] == 3'd0) |=> (sh_q.ratio == RATIO_DEF && sh_q.mask == MASK_DEF)); // R11
    AST_SPARE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd3) |=> $stable(sh_q)); // R9
    AST_MODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd0 && wdata[2:0] != 3'd0) |=> $stable(sh_q.ratio) && $stable(sh_q.mask)); // R12
endmodule

// File: rtl/pixel_lane_sel.sv
module pixel_lane_sel
    import pixel_unpacker_pkg::*;
(
    input  logic [BUS_W-1:0] word,
    input  px_mode_e         mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             nib,
    output logic [IDX_W-1:0] raw
);
    localparam int NPACK = 5;

    logic [IDX_W-1:0] packed_grp [NPACK];

    for (genvar g = 0; g < NPACK; g++) begin : g_pack
        localparam int BPP = 1 << g;
        logic [SHIFT_W-1:0] sh;
        logic [BUS_W-1:0]   shifted;
        always_comb begin
            sh             = SHIFT_W'(cnt) * SHIFT_W'(BPP);
            shifted        = word >> sh;
            packed_grp[g]  = IDX_W'(shifted[BPP-1:0]);
        end
    end

    logic [SHIFT_W-1:0] nsh;
    logic [BUS_W-1:0]   nshifted;

    always_comb begin
        nsh      = SHIFT_W'({cnt, 3'b000}) + (nib ? SHIFT_W'(4) : SHIFT_W'(0));
        nshifted = word >> nsh;
        case (mode)
            MD_BPP1:   raw = packed_grp[0];
            MD_BPP2:   raw = packed_grp[1];
            MD_BPP4:   raw = packed_grp[2];
            MD_BPP8:   raw = packed_grp[3];
            MD_BPP16:  raw = packed_grp[4];
            MD_NIBBLE: raw = IDX_W'(nshifted[3:0]);
            default:   raw = IDX_W'(word[7:0]);
        endcase
    end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import pixel_unpacker_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    input  logic        sclk_stb,
    input  logic [31:0] pix_bus,
    input  logic        nib_hi,
    input  logic [7:0]  vga_px,
    output logic [15:0] pix_idx,
    output logic [7:0]  red,
    output logic [7:0]  green,
    output logic [7:0]  blue,
    output logic        underrun
);
    px_cfg_t   shadow, act_d, act_q;
    px_state_t st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic [IDX_W-1:0] raw;

    pixel_cfg_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .shadow (shadow)
    );

    pixel_lane_sel u_lane (
        .word (st_q.word),
        .mode (act_q.mode),
        .cnt  (st_q.cnt),
        .nib  (st_q.nib),
        .raw  (raw)
    );

    always_comb begin
        if (act_q.ratio == '0) begin
            limit = '0;
        end else if (int'(act_q.ratio) > BUS_W) begin
            limit = CNT_W'(BUS_W - 1);
        end else begin
            limit = CNT_W'(act_q.ratio - RATIO_W'(1));
        end
    end

    always_comb begin
        st_d  = st_q;
        act_d = act_q;
        if (sclk_stb) begin
            act_d      = shadow;
            st_d.word  = pix_bus;
            st_d.cnt   = '0;
            st_d.under = 1'b0;
            st_d.nib   = nib_hi;
        end else if (act_q.mode != MD_PASS) begin
            if (st_q.cnt < limit) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else begin
                st_d.under = 1'b1;
            end
        end
        if (act_d.mode == MD_PASS) begin
            st_d.word = BUS_W'(vga_px);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '{mode: MD_PASS, ratio: RATIO_DEF, mask: MASK_DEF};
            st_q  <= '0;
        end else begin
            act_q <= act_d;
            st_q  <= st_d;
        end
    end

    always_comb begin
        pix_idx  = {raw[IDX_W-1:MASK_W], raw[MASK_W-1:0] & act_q.mask};
        underrun = st_q.under;
        if (act_q.mode == MD_TRUE) begin
            blue  = st_q.word[31:24];
            green = st_q.word[23:16];
            red   = st_q.word[15:8];
        end else begin
            blue  = '0;
            green = '0;
            red   = '0;
        end
    end

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_stb |=> (st_q.cnt == '0)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= limit); // R8
    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !sclk_stb) |=> $stable(pix_idx) && underrun); // R8
    AST_UNDERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_stb |=> !underrun); // R8
    AST_PASS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.mode == MD_PASS) |-> (pix_idx[15:8] == 8'h00 && !underrun)); // R2
    AST_CFG_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_stb |=> $stable(act_q)); // R10
endmodule

// File: tb/pixel_unpacker_bench.sv
module pixel_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        sclk_stb = 1'b0;
    logic [31:0] pix_bus = '0;
    logic        nib_hi = 1'b0;
    logic [7:0]  vga_px = '0;
    logic [15:0] pix_idx;
    logic [7:0]  red, green, blue;
    logic        underrun;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pixel_unpacker u_pixel_unpacker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .sclk_stb(sclk_stb), .pix_bus(pix_bus),
        .nib_hi(nib_hi), .vga_px(vga_px), .pix_idx(pix_idx), .red(red),
        .green(green), .blue(blue), .underrun(underrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic load(input logic [31:0] w, input logic n);
        pix_bus = w; nib_hi = n; sclk_stb = 1'b1;
        step();
        sclk_stb = 1'b0;
    endtask

    function automatic logic [15:0] exp_px(input logic [31:0] w, input int code,
                                           input int k, input logic n, input logic [7:0] m);
        logic [31:0] r;
        if (code >= 1 && code <= 5) begin
            int b = 1 << (code - 1);
            r = (w >> (k * b)) & ((32'h1 << b) - 32'h1);
        end else if (code == 6) begin
            r = (w >> (8 * k + (n ? 4 : 0))) & 32'hF;
        end else begin
            r = {24'h0, w[7:0]};
        end
        return {r[15:8], r[7:0] & m};
    endfunction

    task automatic run_load(input string tag, input logic [31:0] w, input int code,
                            input int cnt, input logic n, input logic [7:0] m);
        load(w, n);
        for (int k = 0; k < cnt; k++) begin
            chk(tag, 32'(pix_idx), 32'(exp_px(w, code, k, n, m)));
            if (k < cnt - 1) step();
        end
    endtask

    function automatic logic [31:0] word_of(input int i);
        case (i)
            0: return 32'h7654_3210;
            1: return 32'hFFFF_0000;
            default: return (32'h9E37_79B9 * 32'(i)) ^ 32'h0F0F_1234;
        endcase
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 idx", 32'(pix_idx), 32'h0);
        chk("R1 rgb", {8'h0, red, green, blue}, 32'h0);
        chk("R1 underrun", 32'(underrun), 32'h0);
        // R2 pass-through sweep with the default mask
        for (int v = 0; v < 256; v++) begin
            vga_px = 8'(v);
            step();
            chk("R2 pass", 32'(pix_idx), 32'(v));
        end
        step();
        chk("R2 no underrun", 32'(underrun), 32'h0);

        // R4 packed widths
        for (int code = 1; code <= 5; code++) begin
            int per = 32 >> (code - 1);
            wr(2'd0, 8'(code));
            wr(2'd1, 8'(per));
            for (int i = 0; i < 5; i++) begin
                run_load("R4 packed", word_of(i), code, per, 1'b0, 8'hFF);
                chk("R6 rgb zero", {8'h0, red, green, blue}, 32'h0);
            end
        end

        // R5 nibble select, both flag values
        wr(2'd0, 8'd6);
        wr(2'd1, 8'd4);
        for (int i = 0; i < 5; i++) begin
            run_load("R5 nib lo", word_of(i), 6, 4, 1'b0, 8'hFF);
            run_load("R5 nib hi", word_of(i), 6, 4, 1'b1, 8'hFF);
        end

        // R6 true colour, R7 overlay suppression
        wr(2'd0, 8'd7);
        wr(2'd1, 8'd1);
        for (int i = 0; i < 5; i++) begin
            logic [31:0] w = word_of(i);
            run_load("R6 overlay", w, 7, 1, 1'b0, 8'hFF);
            chk("R6 colours", {8'h0, red, green, blue}, {8'h0, w[15:8], w[23:16], w[31:24]});
        end
        wr(2'd2, 8'h00);
        load(32'hC1D2E3F4, 1'b0);
        chk("R7 overlay off", 32'(pix_idx), 32'h0);
        chk("R7 colours kept", {8'h0, red, green, blue}, 32'h00E3D2C1);

        // R7 16-bit mode: high byte not masked
        wr(2'd0, 8'd5);
        wr(2'd1, 8'd2);
        wr(2'd2, 8'h0F);
        run_load("R7 mask16", 32'hABCD_5A5A, 5, 2, 1'b0, 8'h0F);

        // R10 mask change while shifting
        wr(2'd0, 8'd4);
        wr(2'd1, 8'd4);
        wr(2'd2, 8'hFF);
        load(32'hF1F2_F3F4, 1'b0);
        chk("R10 px0", 32'(pix_idx), 32'hF4);
        wr(2'd2, 8'h0F);
        chk("R10 px1 old mask", 32'(pix_idx), 32'hF3);
        step();
        chk("R10 px2 old mask", 32'(pix_idx), 32'hF2);
        run_load("R10 new mask", 32'hF1F2_F3F4, 4, 4, 1'b0, 8'h0F);

        // R8 underrun with ratio 2
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'd2);
        run_load("R8 ratio2", 32'h4433_2211, 4, 2, 1'b0, 8'hFF);
        chk("R8 no underrun yet", 32'(underrun), 32'h0);
        step();
        chk("R8 underrun set", 32'(underrun), 32'h1);
        chk("R8 held pixel", 32'(pix_idx), 32'h22);
        step();
        chk("R8 still held", 32'(pix_idx), 32'h22);
        load(32'h8877_6655, 1'b0);
        chk("R8 underrun cleared", 32'(underrun), 32'h0);
        chk("R8 new px0", 32'(pix_idx), 32'h55);
        // R8 ratio 0 behaves as 1
        wr(2'd1, 8'd0);
        load(32'h0000_0099, 1'b0);
        chk("R8 ratio0 px", 32'(pix_idx), 32'h99);
        step();
        chk("R8 ratio0 underrun", 32'(underrun), 32'h1);

        // R9 upper mode bits ignored, spare address ignored
        wr(2'd0, 8'hFC);
        wr(2'd1, 8'd4);
        wr(2'd3, 8'h00);
        run_load("R9 upper bits", 32'h1234_5678, 4, 4, 1'b0, 8'hFF);

        // R12 mode write keeps ratio
        wr(2'd1, 8'd3);
        wr(2'd0, 8'd3);
        run_load("R12 ratio kept", 32'h0000_0CBA, 3, 3, 1'b0, 8'hFF);
        chk("R12 before limit", 32'(underrun), 32'h0);
        step();
        chk("R12 underrun at 3", 32'(underrun), 32'h1);

        // R11 mode-0 write restores ratio and mask
        wr(2'd1, 8'd2);
        wr(2'd2, 8'h3C);
        wr(2'd0, 8'd0);
        load(32'h0, 1'b0);
        vga_px = 8'hFF;
        step();
        chk("R11 mask default", 32'(pix_idx), 32'hFF);
        wr(2'd0, 8'd4);
        load(32'h0000_00A7, 1'b0);
        chk("R11 px0", 32'(pix_idx), 32'hA7);
        step();
        chk("R11 ratio default", 32'(underrun), 32'h1);

        // R2 pass-through with a narrow mask
        wr(2'd0, 8'd0);
        wr(2'd2, 8'h5A);
        load(32'h0, 1'b0);
        for (int v = 0; v < 256; v += 17) begin
            vga_px = 8'(v);
            step();
            chk("R2 masked pass", 32'(pix_idx), 32'(8'(v) & 8'h5A));
        end
        finish_run();
    end
endmodule